// File: doc/BRIEF.md
# DMA Cycle Engine for a Nibble-Wide Low-Pin-Count Bus Target

This block sits on the peripheral side of a 4-bit multiplexed host bus. It takes part in DMA cycles that the host starts. It watches the framing strobe and the nibble lines and recognises a cycle start. It then decodes, one nibble per clock, the cycle kind and direction, the channel number with its terminal-count flag, and the transfer size. Cycles for other channels, other cycle kinds or unsupported sizes are left alone.

For a host-to-peripheral transfer, the engine collects each byte as two nibbles. It waits out the host's turnaround and answers with a SYNC. It hands the byte to a local FIFO, then gives the bus back. For a peripheral-to-host transfer, it waits out the turnaround and pops a byte from the local FIFO. It signals SYNC, then drives the byte as two nibbles. Either direction carries one or two bytes. While the FIFO cannot take or supply a byte, the engine stretches the cycle with short-wait SYNCs.

The local side may withdraw its request after the host has already granted the cycle. A configuration input then chooses one of two behaviours. In the first, the engine stays silent so that the host aborts. In the second, it completes the cycle with filler data and does not touch the FIFO.

Top module: `lpc_dma_target`

## Requirements
- R1: After reset, `bus_nib_oe`, `rx_valid`, `tx_pop` and `tc_out` are low. A cycle begins in a clock where `bus_frame_n` is low and `bus_nib_in` is 0000; the following clocks (with `bus_frame_n` high) carry the type, channel and size nibbles in that order.
- R2: A type nibble of 1000 selects a host-to-peripheral transfer and 1010 selects a peripheral-to-host transfer. Any other type value makes the engine ignore the cycle, so it never drives the bus for it.
- R3: In the channel nibble, bits [2:0] are compared with `own_chan`. On a mismatch the cycle is ignored and the bus is never driven.
- R4: A size nibble of 0000 means one byte and 0001 means two bytes. Any other size value makes the engine ignore the cycle.
- R5: Host-to-peripheral transfers run in this order for each byte:
  - The host sends the low nibble, then the high nibble, then holds two turnaround clocks.
  - The engine drives SYNC 0000. In that same clock it presents the byte on `rx_data` with `rx_valid` high.
  - The engine drives 1111 for one clock, then releases the bus.
- R6: Peripheral-to-host transfers start with two host turnaround clocks. Then, for each byte:
  - The engine drives SYNC 0000 with `tx_pop` high. The byte on `tx_data` is captured in that clock.
  - In the next two clocks the engine drives the low nibble, then the high nibble.
  - After the last byte the engine drives 1111 for one clock, then releases the bus.
- R7: While a SYNC is due and `rx_full` (host-to-peripheral) or `tx_empty` (peripheral-to-host) is high, the engine drives SYNC 0101 with no `rx_valid` or `tx_pop`.
- R8: The terminal-count flag is bit 3 of the channel nibble and is held for the cycle. `tc_out` pulses for one clock only on the last byte of the transfer size. For host-to-peripheral it pulses in the SYNC 0000 clock of that byte. For peripheral-to-host it pulses in the clock that drives that byte's high nibble. It never pulses when the flag is clear.
- R9: If `req_abandon` is high in the size clock and `abandon_fill` is low, the engine stays silent. It never drives the bus and raises neither `rx_valid` nor `tx_pop` for that cycle.
- R10: If `req_abandon` is high in the size clock and `abandon_fill` is high, the engine completes the cycle:
  - Every SYNC is 0000 at once, whatever the FIFO flags say.
  - Data driven to the host is FFh.
  - `rx_valid`, `tx_pop` and `tc_out` stay low.
- R11: `bus_frame_n` low in any clock ends the current cycle. The bus is released from the next clock. If the nibble in that clock is 0000, a new cycle decode starts from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_frame_n | input | 1 | Host framing strobe, active low |
| bus_nib_in | input | 4 | Nibble lines as seen from the bus |
| bus_nib_out | output | 4 | Nibble the engine drives |
| bus_nib_oe | output | 1 | Output enable for `bus_nib_out` |
| own_chan | input | 3 | DMA channel this engine serves |
| req_abandon | input | 1 | Local side has withdrawn its request |
| abandon_fill | input | 1 | 1: complete abandoned cycles with filler; 0: stay silent |
| rx_data | output | 8 | Byte received from the host |
| rx_valid | output | 1 | Push strobe for `rx_data` into the local FIFO |
| rx_full | input | 1 | Local receive FIFO cannot accept a byte |
| tx_data | input | 8 | Head byte of the local transmit FIFO |
| tx_pop | output | 1 | Pops the transmit FIFO head |
| tx_empty | input | 1 | Local transmit FIFO has no byte |
| tc_out | output | 1 | Terminal-count pulse on the last byte |

## Verification
The assertions assume that the host keeps to the bus protocol. It drives nibbles and the framing strobe synchronously, and it never takes the bus back while the engine owns it, apart from a frame abort. They also assume the FIFO flags are truthful in the clock they are sampled. Within those limits they require three things: strobes to the FIFO only when the flags allow, a ready SYNC in every push clock, and a released bus after every framing strobe. The directed stimulus changes every input on the falling edge and holds it through the rising edge. `req_abandon` is changed only between cycles, so the size clock always sees a settled value.

// File: rtl/dmae_pkg.sv
package dmae_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;
    localparam int CHAN_W = 3;
    localparam int LANES  = BYTE_W / NIB_W;

    localparam logic [NIB_W-1:0] NIB_START     = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_TYPE_RD   = 4'b1000;
    localparam logic [NIB_W-1:0] NIB_TYPE_WR   = 4'b1010;
    localparam logic [NIB_W-1:0] NIB_SYNC_RDY  = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_SYNC_WAIT = 4'b0101;
    localparam logic [NIB_W-1:0] NIB_TAR       = 4'b1111;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TYPE,
        ST_CHAN,
        ST_SIZE,
        ST_RD_LO,
        ST_RD_HI,
        ST_HTAR1,
        ST_HTAR2,
        ST_SYNC,
        ST_WR_LO,
        ST_WR_HI,
        ST_PTAR1,
        ST_PTAR2
    } seq_state_e;

    typedef enum logic [2:0] {
        DRV_OFF,
        DRV_SYNC_RDY,
        DRV_SYNC_WAIT,
        DRV_LO,
        DRV_HI,
        DRV_TAR
    } drive_sel_e;

    typedef struct packed {
        logic is_start;
        logic type_ok;
        logic type_wr;
        logic chan_hit;
        logic tc_bit;
        logic size_ok;
        logic size_two;
    } field_dec_t;

    typedef struct packed {
        logic to_host;
        logic tc;
        logic two;
        logic fill;
    } cyc_ctx_t;

    function automatic logic [NIB_W-1:0] drive_nibble(input drive_sel_e sel,
                                                      input logic [BYTE_W-1:0] b);
        logic [NIB_W-1:0] r;
        unique case (sel)
            DRV_SYNC_RDY:  r = NIB_SYNC_RDY;
            DRV_SYNC_WAIT: r = NIB_SYNC_WAIT;
            DRV_LO:        r = b[NIB_W-1:0];
            DRV_HI:        r = b[BYTE_W-1:NIB_W];
            DRV_TAR:       r = NIB_TAR;
            default:       r = NIB_TAR;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dmae_field_dec.sv
module dmae_field_dec
    import dmae_pkg::*;
(
    input  logic [NIB_W-1:0]  nib,
    input  logic [CHAN_W-1:0] own_chan,
    output field_dec_t        dec
);

    always_comb begin
        dec.is_start = (nib == NIB_START);
        dec.type_ok  = (nib == NIB_TYPE_RD) || (nib == NIB_TYPE_WR);
        dec.type_wr  = (nib == NIB_TYPE_WR);
        dec.chan_hit = (nib[CHAN_W-1:0] == own_chan);
        dec.tc_bit   = nib[NIB_W-1];
        dec.size_ok  = (nib[NIB_W-1:1] == '0);
        dec.size_two = nib[0];
    end

endmodule

// File: rtl/dmae_seq.sv
module dmae_seq
    import dmae_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  field_dec_t       dec,
    input  logic             abandon,
    input  logic             abandon_fill,
    input  logic             rx_full,
    input  logic             tx_empty,
    output logic [LANES-1:0] cap,
    output logic             load_tx,
    output logic             use_fill,
    output drive_sel_e       drv,
    output logic             rx_valid,
    output logic             tx_pop,
    output logic             tc_out
);

    seq_state_e st_q, st_d;
    cyc_ctx_t   ctx_q, ctx_d;
    logic       idx_q, idx_d;
    logic       last, ready, sync_ok;

    assign last    = (idx_q == ctx_q.two);
    assign ready   = ctx_q.fill || (ctx_q.to_host ? !tx_empty : !rx_full);
    assign sync_ok = (st_q == ST_SYNC) && ready;

    always_comb begin
        st_d  = st_q;
        ctx_d = ctx_q;
        idx_d = idx_q;
        unique case (st_q)
            ST_IDLE: st_d = ST_IDLE;
            ST_TYPE: begin
                if (dec.type_ok) begin
                    ctx_d.to_host = dec.type_wr;
                    st_d          = ST_CHAN;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_CHAN: begin
                if (dec.chan_hit) begin
                    ctx_d.tc = dec.tc_bit;
                    st_d     = ST_SIZE;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_SIZE: begin
                if (dec.size_ok && !(abandon && !abandon_fill)) begin
                    ctx_d.two  = dec.size_two;
                    ctx_d.fill = abandon;
                    idx_d      = 1'b0;
                    st_d       = ctx_q.to_host ? ST_HTAR1 : ST_RD_LO;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_RD_LO: st_d = ST_RD_HI;
            ST_RD_HI: st_d = ST_HTAR1;
            ST_HTAR1: st_d = ST_HTAR2;
            ST_HTAR2: st_d = ST_SYNC;
            ST_SYNC: begin
                if (ready) st_d = ctx_q.to_host ? ST_WR_LO : ST_PTAR1;
            end
            ST_WR_LO: st_d = ST_WR_HI;
            ST_WR_HI: begin
                if (last) begin
                    st_d = ST_PTAR1;
                end else begin
                    idx_d = 1'b1;
                    st_d  = ST_SYNC;
                end
            end
            ST_PTAR1: st_d = ST_PTAR2;
            ST_PTAR2: begin
                if (!ctx_q.to_host && !last) begin
                    idx_d = 1'b1;
                    st_d  = ST_RD_LO;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
        // a framing strobe overrides whatever the cycle was doing
        if (!frame_n) st_d = dec.is_start ? ST_TYPE : ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            ctx_q <= '0;
            idx_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            ctx_q <= ctx_d;
            idx_q <= idx_d;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_SYNC:  drv = ready ? DRV_SYNC_RDY : DRV_SYNC_WAIT;
            ST_WR_LO: drv = DRV_LO;
            ST_WR_HI: drv = DRV_HI;
            ST_PTAR1: drv = DRV_TAR;
            default:  drv = DRV_OFF;
        endcase
    end

    assign cap[0]   = (st_q == ST_RD_LO) && frame_n;
    assign cap[1]   = (st_q == ST_RD_HI) && frame_n;
    assign load_tx  = sync_ok && ctx_q.to_host;
    assign use_fill = ctx_q.fill;
    assign rx_valid = sync_ok && !ctx_q.to_host && !ctx_q.fill;
    assign tx_pop   = load_tx && !ctx_q.fill;
    assign tc_out   = ctx_q.tc && !ctx_q.fill && last &&
                      ((sync_ok && !ctx_q.to_host) ||
                       ((st_q == ST_WR_HI) && ctx_q.to_host));

endmodule

// File: rtl/dmae_datapath.sv
module dmae_datapath
    import dmae_pkg::*;
#(
    parameter logic [BYTE_W-1:0] FILL_BYTE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NIB_W-1:0]  nib_in,
    input  logic [LANES-1:0]  cap,
    input  logic              load_tx,
    input  logic              use_fill,
    input  logic [BYTE_W-1:0] tx_data,
    input  drive_sel_e        drv,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [NIB_W-1:0]  nib_out,
    output logic              nib_oe
);

    logic [BYTE_W-1:0] tx_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [NIB_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)         lane_q <= '0;
            else if (cap[g]) lane_q <= nib_in;
        end
        assign rx_byte[g*NIB_W +: NIB_W] = lane_q;
    end

    always_ff @(posedge clk) begin
        if (rst)          tx_q <= '0;
        else if (load_tx) tx_q <= use_fill ? FILL_BYTE : tx_data;
    end

    assign nib_oe  = (drv != DRV_OFF);
    assign nib_out = drive_nibble(drv, tx_q);

endmodule

// File: rtl/lpc_dma_target.sv
module lpc_dma_target
    import dmae_pkg::*;
#(
    parameter logic [BYTE_W-1:0] FILL_BYTE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_frame_n,
    input  logic [NIB_W-1:0]  bus_nib_in,
    output logic [NIB_W-1:0]  bus_nib_out,
    output logic              bus_nib_oe,
    input  logic [CHAN_W-1:0] own_chan,
    input  logic              req_abandon,
    input  logic              abandon_fill,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_full,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              tx_empty,
    output logic              tc_out
);

    field_dec_t       dec;
    logic [LANES-1:0] cap;
    logic             load_tx;
    logic             use_fill;
    drive_sel_e       drv;

    dmae_field_dec u_dec (
        .nib      (bus_nib_in),
        .own_chan (own_chan),
        .dec      (dec)
    );

    dmae_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .frame_n      (bus_frame_n),
        .dec          (dec),
        .abandon      (req_abandon),
        .abandon_fill (abandon_fill),
        .rx_full      (rx_full),
        .tx_empty     (tx_empty),
        .cap          (cap),
        .load_tx      (load_tx),
        .use_fill     (use_fill),
        .drv          (drv),
        .rx_valid     (rx_valid),
        .tx_pop       (tx_pop),
        .tc_out       (tc_out)
    );

    dmae_datapath #(.FILL_BYTE(FILL_BYTE)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .nib_in   (bus_nib_in),
        .cap      (cap),
        .load_tx  (load_tx),
        .use_fill (use_fill),
        .tx_data  (tx_data),
        .drv      (drv),
        .rx_byte  (rx_data),
        .nib_out  (bus_nib_out),
        .nib_oe   (bus_nib_oe)
    );

endmodule

// File: rtl/lpc_dma_target_chk.sv
module lpc_dma_target_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_frame_n,
    input logic [3:0] bus_nib_out,
    input logic       bus_nib_oe,
    input logic       rx_valid,
    input logic       rx_full,
    input logic       tx_pop,
    input logic       tx_empty,
    input logic       tc_out
);

    p_pop_needs_data_r7: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> !tx_empty);

    p_push_needs_room_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !rx_full);

    p_push_on_ready_sync_r5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (bus_nib_oe && bus_nib_out == 4'b0000));

    p_data_after_pop_r6: assert property (@(posedge clk) disable iff (rst)
        tx_pop |=> bus_nib_oe);

    p_frame_releases_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_frame_n |=> !bus_nib_oe);

    p_tc_with_byte_r8: assert property (@(posedge clk) disable iff (rst)
        tc_out |-> (rx_valid || (bus_nib_oe && $past(bus_nib_oe) && $past(bus_nib_oe, 2))));

    p_one_local_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && tx_pop));

endmodule

bind lpc_dma_target lpc_dma_target_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_frame_n (bus_frame_n),
    .bus_nib_out (bus_nib_out),
    .bus_nib_oe  (bus_nib_oe),
    .rx_valid    (rx_valid),
    .rx_full     (rx_full),
    .tx_pop      (tx_pop),
    .tx_empty    (tx_empty),
    .tc_out      (tc_out)
);

// File: tb/lpc_dma_target_tb.sv
module lpc_dma_target_tb;

    localparam logic [2:0] CH = 3'd5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_n = 1'b1;
    logic [3:0] nib_in = 4'hF;
    logic [3:0] nib_out;
    logic       nib_oe;
    logic       abandon = 1'b0;
    logic       fill = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_full = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_pop;
    logic       tx_empty = 1'b0;
    logic       tc_out;

    logic       want_full = 1'b0;
    logic       want_empty = 1'b0;
    logic [7:0] want_txd = 8'h00;

    logic       s_oe, s_rxv, s_pop, s_tc;
    logic [3:0] s_out;
    logic [7:0] s_rxd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lpc_dma_target u_dut (
        .clk (clk), .rst (rst),
        .bus_frame_n (frame_n), .bus_nib_in (nib_in),
        .bus_nib_out (nib_out), .bus_nib_oe (nib_oe),
        .own_chan (CH), .req_abandon (abandon), .abandon_fill (fill),
        .rx_data (rx_data), .rx_valid (rx_valid), .rx_full (rx_full),
        .tx_data (tx_data), .tx_pop (tx_pop), .tx_empty (tx_empty),
        .tc_out (tc_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one bus clock: drive during the low phase, observe, then let the edge pass
    task automatic cyc(input logic f, input logic [3:0] n);
        @(negedge clk);
        frame_n  = f;
        nib_in   = n;
        rx_full  = want_full;
        tx_empty = want_empty;
        tx_data  = want_txd;
        #1;
        s_oe  = nib_oe;
        s_out = nib_out;
        s_rxv = rx_valid;
        s_rxd = rx_data;
        s_pop = tx_pop;
        s_tc  = tc_out;
        @(posedge clk);
    endtask

    task automatic hdr(input logic [3:0] tp, input logic tc, input logic [2:0] ch,
                       input logic [3:0] sz);
        cyc(1'b0, 4'h0);
        cyc(1'b1, tp);
        cyc(1'b1, {tc, ch});
        cyc(1'b1, sz);
    endtask

    task automatic t_reset();
        cyc(1'b1, 4'hF);
        chk("R1 reset outputs quiet", {s_oe, s_rxv, s_pop, s_tc}, 4'b0000);
    endtask

    task automatic t_read(input logic two, input logic tc, input logic [7:0] b0,
                          input logic [7:0] b1, input int waits);
        hdr(4'b1000, tc, CH, {3'b000, two});
        for (int i = 0; i <= int'(two); i++) begin
            logic [7:0] b;
            b = (i == 0) ? b0 : b1;
            cyc(1'b1, b[3:0]);
            chk("R5 bus free during host data", s_oe, 1'b0);
            cyc(1'b1, b[7:4]);
            cyc(1'b1, 4'hF);
            cyc(1'b1, 4'hF);
            chk("R5 bus free during host turnaround", s_oe, 1'b0);
            want_full = 1'b1;
            for (int w = 0; w < waits; w++) begin
                cyc(1'b1, 4'hF);
                chk("R7 short wait while full", {s_oe, s_out, s_rxv, s_tc}, {1'b1, 4'h5, 1'b0, 1'b0});
            end
            want_full = 1'b0;
            cyc(1'b1, 4'hF);
            chk("R5 ready sync", {s_oe, s_out}, {1'b1, 4'h0});
            chk("R5 byte pushed low nibble first", {s_rxv, s_rxd}, {1'b1, b});
            chk("R8 tc only on last byte", s_tc, tc && (i == int'(two)));
            cyc(1'b1, 4'hF);
            chk("R5 peripheral turnaround", {s_oe, s_out}, {1'b1, 4'hF});
            cyc(1'b1, 4'hF);
            chk("R5 bus released", s_oe, 1'b0);
        end
    endtask

    task automatic t_write(input logic two, input logic tc, input logic [7:0] b0,
                           input logic [7:0] b1, input int waits);
        hdr(4'b1010, tc, CH, {3'b000, two});
        cyc(1'b1, 4'hF);
        cyc(1'b1, 4'hF);
        chk("R6 bus free during host turnaround", s_oe, 1'b0);
        for (int i = 0; i <= int'(two); i++) begin
            logic [7:0] b;
            b = (i == 0) ? b0 : b1;
            want_empty = 1'b1;
            for (int w = 0; w < waits; w++) begin
                cyc(1'b1, 4'hF);
                chk("R7 short wait while empty", {s_oe, s_out, s_pop}, {1'b1, 4'h5, 1'b0});
            end
            want_empty = 1'b0;
            want_txd   = b;
            cyc(1'b1, 4'hF);
            chk("R6 ready sync with pop", {s_oe, s_out, s_pop}, {1'b1, 4'h0, 1'b1});
            want_empty = 1'b1;
            want_txd   = 8'h00;
            cyc(1'b1, 4'hF);
            chk("R6 low nibble first", {s_oe, s_out, s_tc}, {1'b1, b[3:0], 1'b0});
            cyc(1'b1, 4'hF);
            chk("R6 high nibble second", {s_oe, s_out}, {1'b1, b[7:4]});
            chk("R8 tc on last byte high nibble", s_tc, tc && (i == int'(two)));
        end
        cyc(1'b1, 4'hF);
        chk("R6 peripheral turnaround", {s_oe, s_out}, {1'b1, 4'hF});
        cyc(1'b1, 4'hF);
        chk("R6 bus released", s_oe, 1'b0);
        want_empty = 1'b0;
    endtask

    task automatic t_ignored(input string req, input logic [3:0] tp, input logic [2:0] ch,
                             input logic [3:0] sz);
        logic any;
        want_full  = 1'b0;
        want_empty = 1'b0;
        any = 1'b0;
        hdr(tp, 1'b1, ch, sz);
        for (int k = 0; k < 10; k++) begin
            cyc(1'b1, 4'hF);
            any = any | s_oe | s_rxv | s_pop | s_tc;
        end
        chk(req, any, 1'b0);
    endtask

    task automatic t_abandon_fill();
        abandon = 1'b1;
        fill    = 1'b1;
        // host-to-peripheral with a full FIFO: completes anyway, nothing pushed
        want_full = 1'b1;
        hdr(4'b1000, 1'b1, CH, 4'h0);
        cyc(1'b1, 4'h3); cyc(1'b1, 4'hC); cyc(1'b1, 4'hF); cyc(1'b1, 4'hF);
        cyc(1'b1, 4'hF);
        chk("R10 immediate ready sync", {s_oe, s_out}, {1'b1, 4'h0});
        chk("R10 no push no tc", {s_rxv, s_tc}, 2'b00);
        cyc(1'b1, 4'hF);
        cyc(1'b1, 4'hF);
        chk("R10 released after read", s_oe, 1'b0);
        want_full = 1'b0;
        // peripheral-to-host with an empty FIFO: filler data, no pop
        want_empty = 1'b1;
        want_txd   = 8'h12;
        hdr(4'b1010, 1'b1, CH, 4'h0);
        cyc(1'b1, 4'hF); cyc(1'b1, 4'hF);
        cyc(1'b1, 4'hF);
        chk("R10 ready sync no pop", {s_oe, s_out, s_pop}, {1'b1, 4'h0, 1'b0});
        cyc(1'b1, 4'hF);
        chk("R10 filler low nibble", {s_oe, s_out}, {1'b1, 4'hF});
        cyc(1'b1, 4'hF);
        chk("R10 filler high nibble no tc", {s_oe, s_out, s_tc}, {1'b1, 4'hF, 1'b0});
        cyc(1'b1, 4'hF);
        cyc(1'b1, 4'hF);
        chk("R10 released after write", s_oe, 1'b0);
        want_empty = 1'b0;
        want_txd   = 8'h00;
        abandon = 1'b0;
        fill    = 1'b0;
    endtask

    task automatic t_abandon_silent();
        abandon = 1'b1;
        fill    = 1'b0;
        t_ignored("R9 silent on abandoned write", 4'b1010, CH, 4'h0);
        t_ignored("R9 silent on abandoned read", 4'b1000, CH, 4'h1);
        abandon = 1'b0;
    endtask

    task automatic t_frame_abort();
        want_empty = 1'b1;
        hdr(4'b1010, 1'b0, CH, 4'h0);
        cyc(1'b1, 4'hF); cyc(1'b1, 4'hF);
        cyc(1'b1, 4'hF);
        chk("R11 engine waiting before abort", {s_oe, s_out}, {1'b1, 4'h5});
        cyc(1'b0, 4'h3);
        cyc(1'b1, 4'hF);
        chk("R11 bus released after frame", s_oe, 1'b0);
        want_empty = 1'b0;
        cyc(1'b1, 4'hF);
        chk("R11 stays idle", {s_oe, s_pop}, 2'b00);
        // restart in the middle of a header: the strobe with 0000 begins anew
        cyc(1'b0, 4'h0);
        cyc(1'b1, 4'b1000);
        t_read(1'b0, 1'b1, 8'h7E, 8'h00, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read(1'b0, 1'b0, 8'hA5, 8'h00, 0);
        t_read(1'b1, 1'b1, 8'h3C, 8'h96, 2);
        t_write(1'b0, 1'b1, 8'h5A, 8'h00, 0);
        t_write(1'b1, 1'b0, 8'hE1, 8'h2D, 3);
        t_write(1'b1, 1'b1, 8'h81, 8'h18, 1);
        t_ignored("R3 other channel ignored", 4'b1000, 3'd2, 4'h0);
        t_ignored("R2 other cycle type ignored", 4'b0100, CH, 4'h0);
        t_ignored("R4 unsupported size ignored", 4'b1010, CH, 4'h2);
        t_abandon_silent();
        t_abandon_fill();
        t_frame_abort();
        t_read(1'b0, 1'b0, 8'h0F, 8'h00, 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule